// File: doc/BRIEF.md
# I2C Multi-Master Arbitrating Transmitter

This block is the master side of an I2C port on a bus that other masters share. It drives SCL and SDA through open-drain enables: an enable pulls the line low, and a released line floats high. It creates Start, Repeated Start, Stop and Acknowledge conditions on command strobes. It transmits bytes that arrive on a valid/ready write port. Each phase of SCL lasts a programmable number of clock cycles. Whenever the engine lets SDA float high while SCL is high, it compares the synchronized SDA level against that released level. A low reading means another master has won the bus.

On lost arbitration the engine drops back to idle at once and releases both lines. It empties its byte buffer and clears whichever condition it was running. It raises a sticky collision flag and a one-cycle collision pulse. It then keeps watching the bus. When the next Stop appears, it emits a completion pulse so that software knows the bus is free again. A separate watcher records the most recent Start and Stop seen on the bus and derives a bus-free indication from them. A Start command is taken only while the bus is free.

The write port takes a byte when `tx_valid` and `tx_ready` are both high on a clock edge. `tx_ready` is low while a byte is buffered or in flight, and while the block is disabled. The producer holds `tx_valid` and `tx_data` until the handshake. A byte waits in the buffer until the engine holds the bus after a Start.

Top module: `i2c_arb_master`

## Requirements
- R1: Reset or `enable` low returns the engine to idle. In idle both line enables are low, and the buffer, `start_seen`, `stop_seen` and `cond_busy` are cleared. `coll_flag` is cleared only by reset or `coll_clr`.
- R2: `cmd_start` in idle with `bus_free` high makes SDA fall while SCL is high, then holds SCL low and pulses `done_irq`. `cmd_start` is ignored when the bus is not free.
- R3: A buffered byte is sent most significant bit first. SDA changes only while SCL is low. On the ninth clock SDA is released and the level sampled goes to `ack_n`. The buffer then empties and `done_irq` pulses.
- R4: `tx_ready` equals `enable` and not `buf_full`. A handshake sets `buf_full` on the next cycle.
- R5: While the bus is held and no byte is buffered, one of the following is taken, highest priority first: `cmd_rstart`, `cmd_stop`, `cmd_ack`. `cmd_ack` drives one clock with SDA at the level of `ack_bit`. Each of these pulses `done_irq` when it ends. Condition commands given in a state that does not accept them are ignored. `cond_busy` bit 0 marks Start, bit 1 Repeated Start, bit 2 Stop and bit 3 Acknowledge, with at most one bit set.
- R6: Each SCL high or low phase lasts `div`+1 clock cycles (`div` of at least 3).
- R7: At the end of each SCL-high phase in which SDA is released (in Start, Repeated Start, data bits, Acknowledge or Stop), a low synchronized SDA sets `coll_flag` and pulses `coll_irq`. `coll_flag` holds until `coll_clr`.
- R8: In the cycle `coll_irq` is high, both line enables are low, `buf_full` is 0 and `cond_busy` is 0.
- R9: After a collision, the next Stop seen on the bus pulses `done_irq`.
- R10: A byte written after a collision is sent from its most significant bit.
- R11: SDA falling while SCL is high sets `start_seen` and clears `stop_seen`. SDA rising while SCL is high does the reverse. Both inputs pass through two-flop synchronizers first.
- R12: `bus_free` is high when `stop_seen` is set, or when neither `start_seen` nor `stop_seen` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low aborts and clears |
| div | input | DIV_W | SCL phase length minus one, in cycles |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte buffer can accept |
| cmd_start | input | 1 | Start condition strobe |
| cmd_rstart | input | 1 | Repeated Start strobe |
| cmd_stop | input | 1 | Stop condition strobe |
| cmd_ack | input | 1 | Acknowledge clock strobe |
| ack_bit | input | 1 | SDA level for the Acknowledge clock |
| coll_clr | input | 1 | Clears the collision flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| buf_full | output | 1 | Byte buffered or in flight |
| ack_n | output | 1 | SDA level sampled on the ninth clock |
| cond_busy | output | 4 | Condition in progress, one bit per kind |
| start_seen | output | 1 | Last bus event was a Start |
| stop_seen | output | 1 | Last bus event was a Stop |
| bus_free | output | 1 | Bus may be claimed |
| coll_flag | output | 1 | Sticky lost-arbitration flag |
| done_irq | output | 1 | Completion or post-collision Stop pulse |
| coll_irq | output | 1 | Lost-arbitration pulse |

## Verification
On every cycle the checker confirms the following:
- The lines, buffer and condition bits are released when a collision is reported.
- The collision flag stays set until it is cleared.
- The Start and Stop records never coexist.
- Disabling clears the lines and the records.
- At most one condition is busy.
- Each accepted write fills the buffer.

Only the bench scenarios can show the rest. These are the bit order and ninth-clock release seen on the wires, the phase length, an arbitration loss during a data bit and during a Start, the Stop pulse after a loss, a Start refused on a busy bus, and commands ignored in idle.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_START, ST_RSTART, ST_BYTE, ST_ACK, ST_STOP
  } eng_state_t;

  localparam int COND_W     = 4;
  localparam int COND_START = 0;
  localparam int COND_RSTRT = 1;
  localparam int COND_STOP  = 2;
  localparam int COND_ACK   = 3;
  localparam int BYTE_W     = 8;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/i2c_phase_div.sv
module i2c_phase_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  assign tick = run && (cnt == div);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free
);
  logic scl_p, sda_p;
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
  assign bus_free  = stop_seen || (!start_seen && !stop_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1; sda_p <= 1'b1;
      start_seen <= 1'b0; stop_seen <= 1'b0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (!enable) begin
        start_seen <= 1'b0; stop_seen <= 1'b0;
      end else if (start_det) begin
        start_seen <= 1'b1; stop_seen <= 1'b0;
      end else if (stop_det) begin
        start_seen <= 1'b0; stop_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_arb_engine.sv
module i2c_arb_engine
  import i2c_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  output logic              run,
  input  logic              sda_s,
  input  logic              stop_det,
  input  logic              bus_free,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_ack,
  input  logic              ack_bit,
  input  logic              coll_clr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              buf_full,
  output logic              ack_n,
  output logic [COND_W-1:0] cond_busy,
  output logic              coll_flag,
  output logic              done_irq,
  output logic              coll_irq
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  eng_state_t        state;
  logic [1:0]        phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              hold_sda, ack_low, sda_q, watch;
  logic              scl_low, sda_want, chk, lost;

  // What the lines should be in each state and phase, and where SDA is released while SCL is high.
  always_comb begin
    scl_low = 1'b0; sda_want = 1'b0; chk = 1'b0;
    unique case (state)
      ST_HOLD:   begin scl_low = 1'b1; sda_want = hold_sda; end
      ST_START:  begin sda_want = (phase != 2'd0); chk = (phase == 2'd0); end
      ST_RSTART: begin scl_low = (phase == 2'd0); sda_want = (phase == 2'd2); chk = (phase == 2'd1); end
      ST_BYTE:   begin
        scl_low  = (phase == 2'd0);
        sda_want = (bit_cnt != LAST_BIT) && !shreg[BYTE_W-1];
        chk      = (phase == 2'd1) && (bit_cnt != LAST_BIT) && shreg[BYTE_W-1];
      end
      ST_ACK:    begin scl_low = (phase == 2'd0); sda_want = ack_low; chk = (phase == 2'd1) && !ack_low; end
      ST_STOP:   begin scl_low = (phase == 2'd0); sda_want = (phase != 2'd2); chk = (phase == 2'd2); end
      default:   ;
    endcase
  end

  assign lost     = tick && chk && !sda_s;
  assign run      = (state != ST_IDLE) && (state != ST_HOLD);
  assign scl_oe   = scl_low;
  assign sda_oe   = sda_q;
  assign tx_ready = enable && !buf_full;

  assign cond_busy[COND_START] = (state == ST_START);
  assign cond_busy[COND_RSTRT] = (state == ST_RSTART);
  assign cond_busy[COND_STOP]  = (state == ST_STOP);
  assign cond_busy[COND_ACK]   = (state == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; phase <= '0; bit_cnt <= '0; shreg <= '0;
      hold_sda <= 1'b0; ack_low <= 1'b0; sda_q <= 1'b0; watch <= 1'b0;
      buf_full <= 1'b0; ack_n <= 1'b1; coll_flag <= 1'b0;
      done_irq <= 1'b0; coll_irq <= 1'b0;
    end else if (!enable) begin
      state <= ST_IDLE; phase <= '0; sda_q <= 1'b0; watch <= 1'b0;
      buf_full <= 1'b0; done_irq <= 1'b0; coll_irq <= 1'b0;
      if (coll_clr) coll_flag <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      coll_irq <= 1'b0;
      sda_q    <= sda_want;
      if (coll_clr) coll_flag <= 1'b0;
      if (stop_det && watch) begin
        done_irq <= 1'b1;
        watch    <= 1'b0;
      end
      if (lost) begin
        state <= ST_IDLE; phase <= '0; sda_q <= 1'b0; buf_full <= 1'b0;
        coll_flag <= 1'b1; coll_irq <= 1'b1; watch <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (cmd_start && bus_free) begin state <= ST_START; phase <= '0; end
          ST_HOLD: begin
            phase <= '0;
            if (buf_full)        begin state <= ST_BYTE; bit_cnt <= '0; end
            else if (cmd_rstart) state <= ST_RSTART;
            else if (cmd_stop)   state <= ST_STOP;
            else if (cmd_ack)    begin state <= ST_ACK; ack_low <= !ack_bit; end
          end
          ST_START, ST_ACK: if (tick) begin
            if (phase == 2'd0) phase <= 2'd1;
            else begin
              state <= ST_HOLD; done_irq <= 1'b1;
              hold_sda <= (state == ST_START) ? 1'b1 : ack_low;
            end
          end
          ST_RSTART, ST_STOP: if (tick) begin
            if (phase != 2'd2) phase <= phase + 2'd1;
            else begin
              state    <= (state == ST_RSTART) ? ST_HOLD : ST_IDLE;
              hold_sda <= 1'b1;
              done_irq <= 1'b1;
            end
          end
          ST_BYTE: if (tick) begin
            if (phase == 2'd0) phase <= 2'd1;
            else if (bit_cnt == LAST_BIT) begin
              ack_n <= sda_s; state <= ST_HOLD; hold_sda <= 1'b0;
              buf_full <= 1'b0; done_irq <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= shreg << 1;
              phase   <= 2'd0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
      if (tx_valid && tx_ready) begin
        buf_full <= 1'b1;
        shreg    <= tx_data;
      end
    end
  end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
  import i2c_arb_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_ack,
  input  logic              ack_bit,
  input  logic              coll_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              buf_full,
  output logic              ack_n,
  output logic [COND_W-1:0] cond_busy,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              bus_free,
  output logic              coll_flag,
  output logic              done_irq,
  output logic              coll_irq
);
  logic [1:0] lines_s;
  logic       tick, run, start_det, stop_det;

  i2c_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );

  i2c_phase_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
  );

  i2c_bus_watch u_watch (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .start_det(start_det), .stop_det(stop_det),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free)
  );

  i2c_arb_engine u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .run(run),
    .sda_s(lines_s[0]), .stop_det(stop_det), .bus_free(bus_free),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_ack(cmd_ack), .ack_bit(ack_bit), .coll_clr(coll_clr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_full(buf_full), .ack_n(ack_n),
    .cond_busy(cond_busy), .coll_flag(coll_flag),
    .done_irq(done_irq), .coll_irq(coll_irq)
  );
endmodule

// File: rtl/i2c_arb_master_chk.sv
module i2c_arb_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       coll_clr,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       buf_full,
  input logic [3:0] cond_busy,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       coll_flag,
  input logic       coll_irq
);
  // R8: a collision report comes with everything let go
  a_r8_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    coll_irq |-> (!scl_oe && !sda_oe && !buf_full && cond_busy == 4'd0));

  // R7: the collision flag survives until software clears it
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !coll_clr) |=> coll_flag);

  // R11: the Start and Stop records exclude each other
  a_r11_records_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  // R1: disabling releases the lines and clears the records
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !sda_oe && !start_seen && !stop_seen && !buf_full));

  // R4: an accepted write fills the buffer
  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> buf_full);

  // R5: never two conditions at once
  a_r5_one_condition: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_busy));
endmodule

bind i2c_arb_master i2c_arb_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .coll_clr(coll_clr), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .buf_full(buf_full), .cond_busy(cond_busy), .start_seen(start_seen),
  .stop_seen(stop_seen), .coll_flag(coll_flag), .coll_irq(coll_irq)
);

// File: tb/i2c_arb_master_bench.sv
`timescale 1ns/1ps
module i2c_arb_master_bench;
  localparam int DIV_W = 8;
  localparam int DIV   = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0;
  logic [DIV_W-1:0] div = DIV_W'(DIV);
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, cmd_start = 1'b0, cmd_rstart = 1'b0, cmd_stop = 1'b0;
  logic cmd_ack = 1'b0, ack_bit = 1'b1, coll_clr = 1'b0;
  logic ext_sda_low = 1'b0;
  logic tx_ready, scl_oe, sda_oe, buf_full, ack_n, start_seen, stop_seen;
  logic bus_free, coll_flag, done_irq, coll_irq;
  logic [3:0] cond_busy;
  wire scl_line = ~scl_oe;
  wire sda_line = ~sda_oe & ~ext_sda_low;

  i2c_arb_master #(.DIV_W(DIV_W)) u_i2c_arb_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div(div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_ack(cmd_ack), .ack_bit(ack_bit), .coll_clr(coll_clr),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .buf_full(buf_full), .ack_n(ack_n), .cond_busy(cond_busy),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .coll_flag(coll_flag), .done_irq(done_irq), .coll_irq(coll_irq)
  );

  int checks = 0, fails = 0;
  int done_cnt = 0, coll_cnt = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (done_irq) done_cnt <= done_cnt + 1;
    if (coll_irq) coll_cnt <= coll_cnt + 1;
  end

  // Scoreboard monitor: decodes the wires and pops the expected byte
  logic mon_on = 1'b0;
  logic pscl = 1'b1, psda = 1'b1;
  logic [8:0] bits = '0;
  int nbit = 0, hi_len = 0, last_hi = 0;
  always @(negedge clk) begin
    if (scl_line) hi_len <= hi_len + 1;
    else if (pscl) begin last_hi <= hi_len; hi_len <= 0; end
    if (!mon_on) nbit <= 0;
    else if (pscl && scl_line && psda && !sda_line) nbit <= 0;
    else if (!pscl && scl_line) begin
      bits <= {bits[7:0], sda_line};
      if (nbit == 8) begin
        nbit <= 0;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", int'(bits[7:0]), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(bits[7:0] == e, "R3 byte on wires MSB first", int'(bits[7:0]), int'(e));
        end
      end else nbit <= nbit + 1;
    end
    pscl <= scl_line;
    psda <= sda_line;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit expect_it);
    if (expect_it) exp_q.push_back(b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int start = done_cnt;
    for (int i = 0; i < 2000; i++) begin
      if (done_cnt != start) break;
      @(negedge clk);
    end
    chk(done_cnt != start, tag, done_cnt, start + 1);
  endtask

  task automatic wait_scl_rise;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (scl_line && !pscl) break;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int d0;
    step(4);
    rst_n = 1'b1;
    step(2);
    enable = 1'b1;
    step(4);
    // R1 reset state
    chk(!scl_oe && !sda_oe && !buf_full && !coll_flag && cond_busy == 0, "R1 released after reset",
        {scl_oe, sda_oe, buf_full, coll_flag}, 0);
    chk(tx_ready && bus_free && !start_seen && !stop_seen, "R1 R12 idle flags",
        {tx_ready, bus_free, start_seen, stop_seen}, 4'b1100);

    // R11 R12: another master starts; our Start is refused
    ext_sda_low = 1'b1; step(5);
    chk(start_seen && !stop_seen && !bus_free, "R11 R12 foreign start", {start_seen, stop_seen, bus_free}, 3'b100);
    pulse(cmd_start); step(20);
    chk(!scl_oe && !sda_oe && cond_busy == 0, "R2 start ignored on busy bus", {scl_oe, sda_oe}, 0);
    ext_sda_low = 1'b0; step(5);
    chk(stop_seen && !start_seen && bus_free, "R11 R12 foreign stop", {start_seen, stop_seen, bus_free}, 3'b011);

    // R5: stop command in idle is ignored
    d0 = done_cnt;
    pulse(cmd_stop); step(40);
    chk(!scl_oe && !sda_oe && done_cnt == d0, "R5 stop ignored in idle", done_cnt, d0);

    // R2 R3 R4 R6: start and two bytes
    mon_on = 1'b1;
    pulse(cmd_start);
    wait_done("R2 start completes");
    chk(scl_oe && sda_oe && start_seen && !bus_free, "R2 bus held after start", {scl_oe, sda_oe, start_seen}, 3'b111);
    put_byte(8'hA5, 1'b1);
    chk(buf_full && !tx_ready, "R4 handshake fills buffer", {buf_full, tx_ready}, 2'b10);
    wait_done("R3 byte A5 done");
    chk(!buf_full && ack_n, "R3 buffer empty and ninth bit released", {buf_full, ack_n}, 2'b01);
    chk(last_hi == DIV + 1, "R6 high phase length", last_hi, DIV + 1);
    put_byte(8'h3C, 1'b1);
    wait_done("R3 byte 3C done");

    // R5: repeated start and acknowledge clock
    pulse(cmd_rstart);
    wait_done("R5 repeated start done");
    chk(scl_oe && sda_oe && start_seen, "R5 held after repeated start", {scl_oe, sda_oe, start_seen}, 3'b111);
    mon_on = 1'b0;
    ack_bit = 1'b0;
    pulse(cmd_ack);
    wait_scl_rise();
    chk(!sda_line, "R5 ack clock drives SDA low", sda_line, 0);
    wait_done("R5 ack done");
    mon_on = 1'b1;
    put_byte(8'h96, 1'b1);
    wait_done("R3 byte 96 done");
    pulse(cmd_stop);
    wait_done("R5 stop done");
    step(4);
    chk(stop_seen && bus_free && !scl_oe && !sda_oe, "R5 R11 after stop", {stop_seen, bus_free, scl_oe, sda_oe}, 4'b1100);

    // R7 R8 R9: lose arbitration in a data bit
    pulse(cmd_start);
    wait_done("R2 start before loss");
    put_byte(8'hFF, 1'b0);
    wait_scl_rise();
    @(negedge clk); ext_sda_low = 1'b1;
    step(DIV + 6);
    chk(coll_flag && coll_cnt == 1, "R7 data collision flagged", coll_cnt, 1);
    chk(!scl_oe && !sda_oe && !buf_full && tx_ready && cond_busy == 0, "R8 released after loss",
        {scl_oe, sda_oe, buf_full, tx_ready}, 4'b0001);
    d0 = done_cnt;
    ext_sda_low = 1'b0; step(6);
    chk(done_cnt == d0 + 1 && stop_seen, "R9 stop after loss pulses done", done_cnt, d0 + 1);
    step(10);
    chk(coll_flag, "R7 flag sticky", coll_flag, 1);
    pulse(coll_clr); step(1);
    chk(!coll_flag, "R7 flag cleared by strobe", coll_flag, 0);

    // R7 R8: lose arbitration during a Start
    pulse(cmd_start); step(2);
    ext_sda_low = 1'b1;
    step(DIV + 6);
    chk(coll_flag && coll_cnt == 2 && cond_busy == 0, "R7 R8 start collision", coll_cnt, 2);
    ext_sda_low = 1'b0; step(6);
    pulse(coll_clr); step(2);

    // R10: a new byte after a loss goes out whole
    pulse(cmd_start);
    wait_done("R10 start after loss");
    put_byte(8'h5A, 1'b1);
    wait_done("R10 byte after loss done");
    pulse(cmd_stop);
    wait_done("R10 stop");
    step(4);
    chk(exp_q.size() == 0, "R3 every expected byte seen", exp_q.size(), 0);
    finish_run();
  end
endmodule